// File: doc/BRIEF.md
# Receive Aggregation Window Controller

This block runs one endpoint's receive aggregation. Accepted packets are gathered into a window. The block decides, one packet or tick at a time, when that window has to close. It keeps three counts for the open window: a byte total, a packet count and a count of timer ticks. It checks them against the configured limits and raises a single close event. That event says why the window closed and how many bytes and packets it held.

The time limit is counted in ticks from one of two pulse generators. Tick input 0 is the fine base (100 µs pulses) and tick input 1 is the coarse base (1 ms pulses). The byte limit is given in KB and by default is soft: the packet that crosses it stays in the window. In hard mode, a packet that would push an open window past the limit is kept back for the next window. Two further close sources exist: an end-of-frame marker on a packet, and a force-close request.

The outputs are registered. A close caused by the inputs of cycle t is seen on the ports after the clock edge that ends cycle t.

Top module: `agg_window_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `close_valid` is 0 and `win_open` is 0.
- R2: With `cfg_hard_en`=0, a packet that brings the window total to at least `cfg_byte_kb`×1024 bytes stays in the window. The window then closes with cause 4 (byte), and the report includes that packet.
- R3: With `cfg_hard_en`=1, a packet arriving at an open window whose new total would exceed the limit is not added. The window closes with cause 3 (hard byte) and reports only the earlier contents, and that packet opens the next window. A packet that exceeds the limit on its own in an empty window is kept and closes it with cause 4.
- R4: A nonzero `cfg_pkt_lim` closes the window with cause 5 once it holds that many packets. A value of 0 places no limit on the packet count.
- R5: Ticks are counted only while a window is open, starting from the cycle after its first packet. Only the base picked by `cfg_time_sel` is counted (0 = `tick_fine`, 1 = `tick_coarse`). Reaching `cfg_time_lim` ticks closes the window with cause 6. A limit of 0 disables the timer.
- R6: With `cfg_eof_en`=1, a packet that has `pkt_eof` set closes the window with cause 2, and that packet is included. With `cfg_eof_en`=0, `pkt_eof` has no effect.
- R7: `force_close` closes the window with cause 1 if the window is open or a packet arrives in the same cycle; that packet is included. When the window is idle and no packet arrives, the request does nothing.
- R8: At most one close event occurs per cycle. `close_valid` is a one-cycle pulse and, when it is set, `close_cause` is 1 to 6. When several conditions hold at once, the priority is force (1), EOF (2), hard byte (3), byte (4), packet (5), time (6). Every close other than a hard-byte close leaves the window idle with all counts cleared.
- R9: While `cfg_enable` is 0, packets are ignored, no close event is raised and any open window is dropped without a report.
- R10: `close_bytes` and `close_pkts` give the byte total and packet count of the window that closed. The packet count saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Aggregation enable |
| cfg_byte_kb | input | 6 | Byte limit in KB |
| cfg_time_lim | input | 5 | Time limit in ticks, 0 = off |
| cfg_pkt_lim | input | 6 | Packet limit, 0 = unlimited |
| cfg_time_sel | input | 1 | Tick base select: 0 fine, 1 coarse |
| cfg_eof_en | input | 1 | End-of-frame closes the window |
| cfg_hard_en | input | 1 | Hard byte-limit mode |
| pkt_valid | input | 1 | A packet is accepted this cycle |
| pkt_bytes | input | 16 | Byte count of the packet |
| pkt_eof | input | 1 | Packet carries the end-of-frame marker |
| tick_fine | input | 1 | Pulse from generator 0 |
| tick_coarse | input | 1 | Pulse from generator 1 |
| force_close | input | 1 | Request to close the window now |
| win_open | output | 1 | A window holds at least one packet |
| close_valid | output | 1 | Close event pulse |
| close_cause | output | 3 | Cause code of the close event |
| close_bytes | output | 17 | Bytes in the closed window |
| close_pkts | output | 8 | Packets in the closed window |

## Verification
The bench targets the case where a packet crosses the limit, in both modes. A design that mixes up soft and hard mode would report the wrong byte total, or would lose the packet that should open the next window. The bench feeds ticks while the window is idle, feeds ticks from the base that is not selected, and sends a packet in the same cycle as a tick. A timer that starts too early, or that listens to both bases, closes the window early. It also drives several close causes in the same cycle and drops the enable in the middle of a window. A wrong priority shows up as the wrong cause code, and a design that keeps stale state shows up as inflated totals in the next window.

// File: rtl/agg_win_pkg.sv
// Shared definitions for the receive aggregation window controller.
// Assumes cause codes are consumed by a neighbour that decodes them as listed.
package agg_win_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_FORCE = 3'd1,
        CAUSE_EOF   = 3'd2,
        CAUSE_HARD  = 3'd3,
        CAUSE_BYTE  = 3'd4,
        CAUSE_PKT   = 3'd5,
        CAUSE_TIME  = 3'd6
    } close_cause_e;

    // Byte limit unit is 1 KB.
    localparam int KB_SHIFT = 10;

endpackage

// File: rtl/agg_tick_sel.sv
// Picks one tick stream out of several pulse generators.
// Assumes each tick is a single-cycle pulse; sel is held steady by configuration.
module agg_tick_sel #(
    parameter int NUM_BASES = 2,
    localparam int SEL_W = (NUM_BASES > 1) ? $clog2(NUM_BASES) : 1
) (
    input  logic [NUM_BASES-1:0] ticks,
    input  logic [SEL_W-1:0]     sel,
    output logic                 tick
);

    logic [NUM_BASES-1:0] hit;

    // Per-base match of the select against each generator.
    for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
        assign hit[g] = ticks[g] && (sel == SEL_W'(g));
    end

    // Purpose: merge the matched generator into one tick.
    always_comb tick = |hit;

endmodule

// File: rtl/agg_close_arb.sv
// Evaluates all close conditions for the current cycle and picks one cause.
// Assumes counts come from registered state, so there is no combinational loop.
module agg_close_arb
    import agg_win_pkg::*;
#(
    parameter int PKT_W  = 16,
    parameter int BLIM_W = 6,
    parameter int TLIM_W = 5,
    parameter int PLIM_W = 6,
    parameter int ACC_W  = 17,
    parameter int PCNT_W = 8
) (
    input  logic              enable,
    input  logic [BLIM_W-1:0] byte_kb,
    input  logic [TLIM_W-1:0] time_lim,
    input  logic [PLIM_W-1:0] pkt_lim,
    input  logic              eof_en,
    input  logic              hard_en,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_bytes,
    input  logic              pkt_eof,
    input  logic              force_req,
    input  logic              tick_sel,
    input  logic              open_q,
    input  logic [ACC_W-1:0]  bytes_q,
    input  logic [PCNT_W-1:0] pkts_q,
    input  logic [TLIM_W-1:0] ticks_q,
    output logic [ACC_W-1:0]  sum_bytes,
    output logic [PCNT_W-1:0] sum_pkts,
    output logic [TLIM_W:0]   ticks_after,
    output logic              fire,
    output logic              carry,
    output close_cause_e      cause,
    output logic [ACC_W-1:0]  rep_bytes,
    output logic [PCNT_W-1:0] rep_pkts
);

    logic [ACC_W-1:0] limit_bytes;
    logic             tick_hit;
    logic             c_force, c_eof, c_hard, c_byte, c_pkt, c_time;

    // Purpose: totals for the window as they would be after this cycle.
    always_comb begin
        limit_bytes = ACC_W'(byte_kb) << KB_SHIFT;
        sum_bytes   = bytes_q + (pkt_valid ? ACC_W'(pkt_bytes) : '0);
        sum_pkts    = (pkt_valid && (pkts_q != '1)) ? pkts_q + 1'b1 : pkts_q;
        tick_hit    = open_q && tick_sel;
        ticks_after = {1'b0, ticks_q} + {{TLIM_W{1'b0}}, tick_hit};
    end

    // Purpose: raw close conditions, each independent of the others.
    always_comb begin
        c_force = force_req && (open_q || pkt_valid);
        c_eof   = pkt_valid && pkt_eof && eof_en;
        c_hard  = hard_en && pkt_valid && open_q && (sum_bytes > limit_bytes);
        c_byte  = pkt_valid && (sum_bytes >= limit_bytes);
        c_pkt   = pkt_valid && (pkt_lim != '0) && (sum_pkts >= PCNT_W'(pkt_lim));
        c_time  = tick_hit && (time_lim != '0) && (ticks_after >= (TLIM_W+1)'(time_lim));
    end

    // Purpose: fixed-priority pick of a single cause.
    always_comb begin
        cause = CAUSE_NONE;
        if (enable) begin
            if (c_force)     cause = CAUSE_FORCE;
            else if (c_eof)  cause = CAUSE_EOF;
            else if (c_hard) cause = CAUSE_HARD;
            else if (c_byte) cause = CAUSE_BYTE;
            else if (c_pkt)  cause = CAUSE_PKT;
            else if (c_time) cause = CAUSE_TIME;
        end
        fire  = (cause != CAUSE_NONE);
        carry = (cause == CAUSE_HARD);
    end

    // Purpose: contents reported for the closing window.
    always_comb begin
        rep_bytes = carry ? bytes_q : sum_bytes;
        rep_pkts  = carry ? pkts_q  : sum_pkts;
    end

endmodule

// File: rtl/agg_win_counters.sv
// Holds the open-window state: open flag, byte total, packet count, tick count.
// Assumes the arbiter supplies next totals and the close decision.
module agg_win_counters #(
    parameter int PKT_W  = 16,
    parameter int TLIM_W = 5,
    parameter int ACC_W  = 17,
    parameter int PCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_bytes,
    input  logic              fire,
    input  logic              carry,
    input  logic [ACC_W-1:0]  sum_bytes,
    input  logic [PCNT_W-1:0] sum_pkts,
    input  logic [TLIM_W:0]   ticks_after,
    output logic              open_q,
    output logic [ACC_W-1:0]  bytes_q,
    output logic [PCNT_W-1:0] pkts_q,
    output logic [TLIM_W-1:0] ticks_q
);

    // Purpose: advance, restart or clear the window counts.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            open_q  <= 1'b0;
            bytes_q <= '0;
            pkts_q  <= '0;
            ticks_q <= '0;
        end else if (fire && carry) begin
            open_q  <= 1'b1;
            bytes_q <= ACC_W'(pkt_bytes);
            pkts_q  <= PCNT_W'(1);
            ticks_q <= '0;
        end else if (fire) begin
            open_q  <= 1'b0;
            bytes_q <= '0;
            pkts_q  <= '0;
            ticks_q <= '0;
        end else begin
            if (pkt_valid) open_q <= 1'b1;
            bytes_q <= sum_bytes;
            pkts_q  <= sum_pkts;
            ticks_q <= ticks_after[TLIM_W] ? '1 : ticks_after[TLIM_W-1:0];
        end
    end

    AST_IDLE_NO_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |-> (ticks_q == '0) && (bytes_q == '0)); // R5

    AST_OPEN_HAS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (pkts_q != '0)); // R10

endmodule

// File: rtl/agg_window_ctrl.sv
// Top of the receive aggregation window controller for one endpoint.
// Assumes ticks are single-cycle pulses and configuration is static inside a window
// (changes take effect on the next evaluated condition).
module agg_window_ctrl
    import agg_win_pkg::*;
#(
    parameter int PKT_W  = 16,
    parameter int BLIM_W = 6,
    parameter int TLIM_W = 5,
    parameter int PLIM_W = 6,
    parameter int PCNT_W = 8,
    localparam int LIM_BITS = BLIM_W + KB_SHIFT,
    localparam int ACC_W = ((LIM_BITS > PKT_W) ? LIM_BITS : PKT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [BLIM_W-1:0] cfg_byte_kb,
    input  logic [TLIM_W-1:0] cfg_time_lim,
    input  logic [PLIM_W-1:0] cfg_pkt_lim,
    input  logic              cfg_time_sel,
    input  logic              cfg_eof_en,
    input  logic              cfg_hard_en,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_bytes,
    input  logic              pkt_eof,
    input  logic              tick_fine,
    input  logic              tick_coarse,
    input  logic              force_close,
    output logic              win_open,
    output logic              close_valid,
    output logic [2:0]        close_cause,
    output logic [ACC_W-1:0]  close_bytes,
    output logic [PCNT_W-1:0] close_pkts
);

    logic              tick_sel;
    logic              open_q;
    logic [ACC_W-1:0]  bytes_q, sum_bytes, rep_bytes;
    logic [PCNT_W-1:0] pkts_q, sum_pkts, rep_pkts;
    logic [TLIM_W-1:0] ticks_q;
    logic [TLIM_W:0]   ticks_after;
    logic              fire, carry;
    close_cause_e      cause;
    close_cause_e      cause_q;

    agg_tick_sel #(.NUM_BASES(2)) u_tick_sel (
        .ticks ({tick_coarse, tick_fine}),
        .sel   (cfg_time_sel),
        .tick  (tick_sel)
    );

    agg_close_arb #(
        .PKT_W(PKT_W), .BLIM_W(BLIM_W), .TLIM_W(TLIM_W),
        .PLIM_W(PLIM_W), .ACC_W(ACC_W), .PCNT_W(PCNT_W)
    ) u_arb (
        .enable      (cfg_enable),
        .byte_kb     (cfg_byte_kb),
        .time_lim    (cfg_time_lim),
        .pkt_lim     (cfg_pkt_lim),
        .eof_en      (cfg_eof_en),
        .hard_en     (cfg_hard_en),
        .pkt_valid   (pkt_valid),
        .pkt_bytes   (pkt_bytes),
        .pkt_eof     (pkt_eof),
        .force_req   (force_close),
        .tick_sel    (tick_sel),
        .open_q      (open_q),
        .bytes_q     (bytes_q),
        .pkts_q      (pkts_q),
        .ticks_q     (ticks_q),
        .sum_bytes   (sum_bytes),
        .sum_pkts    (sum_pkts),
        .ticks_after (ticks_after),
        .fire        (fire),
        .carry       (carry),
        .cause       (cause),
        .rep_bytes   (rep_bytes),
        .rep_pkts    (rep_pkts)
    );

    agg_win_counters #(
        .PKT_W(PKT_W), .TLIM_W(TLIM_W), .ACC_W(ACC_W), .PCNT_W(PCNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .pkt_valid   (pkt_valid),
        .pkt_bytes   (pkt_bytes),
        .fire        (fire),
        .carry       (carry),
        .sum_bytes   (sum_bytes),
        .sum_pkts    (sum_pkts),
        .ticks_after (ticks_after),
        .open_q      (open_q),
        .bytes_q     (bytes_q),
        .pkts_q      (pkts_q),
        .ticks_q     (ticks_q)
    );

    // Purpose: register the close report for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            close_valid <= 1'b0;
            cause_q     <= CAUSE_NONE;
            close_bytes <= '0;
            close_pkts  <= '0;
        end else begin
            close_valid <= fire;
            cause_q     <= cause;
            close_bytes <= fire ? rep_bytes : '0;
            close_pkts  <= fire ? rep_pkts  : '0;
        end
    end

    // Purpose: drive the plain-typed ports.
    always_comb begin
        close_cause = cause_q;
        win_open    = open_q;
    end

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        close_valid |-> (close_cause >= 3'd1) && (close_cause <= 3'd6)); // R8

    AST_CLOSE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (close_valid && (close_cause != 3'd3)) |-> !win_open); // R8

    AST_HARD_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (close_valid && (close_cause == 3'd3)) |-> win_open); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_enable) |-> (!close_valid && !win_open)); // R9

    AST_CLOSE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        close_valid |-> (close_pkts != '0)); // R10

endmodule

// File: tb/agg_window_ctrl_bench.sv
module agg_window_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [5:0]  cfg_byte_kb = 6'd2;
    logic [4:0]  cfg_time_lim = 5'd0;
    logic [5:0]  cfg_pkt_lim = 6'd0;
    logic        cfg_time_sel = 1'b0;
    logic        cfg_eof_en = 1'b0;
    logic        cfg_hard_en = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [15:0] pkt_bytes = '0;
    logic        pkt_eof = 1'b0;
    logic        tick_fine = 1'b0;
    logic        tick_coarse = 1'b0;
    logic        force_close = 1'b0;
    logic        win_open, close_valid;
    logic [2:0]  close_cause;
    logic [16:0] close_bytes;
    logic [7:0]  close_pkts;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int  m_open = 0, m_bytes = 0, m_pkts = 0, m_ticks = 0;
    bit  m_cv = 0;
    int  m_cause = 0, m_cb = 0, m_cp = 0;

    always #5 clk = ~clk;

    agg_window_ctrl u_agg_window_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_byte_kb(cfg_byte_kb),
        .cfg_time_lim(cfg_time_lim), .cfg_pkt_lim(cfg_pkt_lim), .cfg_time_sel(cfg_time_sel),
        .cfg_eof_en(cfg_eof_en), .cfg_hard_en(cfg_hard_en), .pkt_valid(pkt_valid),
        .pkt_bytes(pkt_bytes), .pkt_eof(pkt_eof), .tick_fine(tick_fine),
        .tick_coarse(tick_coarse), .force_close(force_close), .win_open(win_open),
        .close_valid(close_valid), .close_cause(close_cause), .close_bytes(close_bytes),
        .close_pkts(close_pkts)
    );

    // Behavioural reference, evaluated at each rising edge from the stable inputs.
    always @(posedge clk) begin
        int nb, np, nt, lim, cs;
        bit th;
        m_cv = 0; m_cause = 0; m_cb = 0; m_cp = 0;
        if (!rst_n || !cfg_enable) begin
            m_open = 0; m_bytes = 0; m_pkts = 0; m_ticks = 0;
        end else begin
            nb  = m_bytes + (pkt_valid ? int'(pkt_bytes) : 0);
            np  = (pkt_valid && m_pkts < 255) ? m_pkts + 1 : m_pkts;
            th  = (m_open != 0) && (cfg_time_sel ? tick_coarse : tick_fine);
            nt  = th ? m_ticks + 1 : m_ticks;
            lim = int'(cfg_byte_kb) * 1024;
            cs  = 0;
            if (force_close && (m_open != 0 || pkt_valid)) cs = 1;
            else if (pkt_valid && pkt_eof && cfg_eof_en) cs = 2;
            else if (cfg_hard_en && pkt_valid && m_open != 0 && nb > lim) cs = 3;
            else if (pkt_valid && nb >= lim) cs = 4;
            else if (pkt_valid && cfg_pkt_lim != 0 && np >= int'(cfg_pkt_lim)) cs = 5;
            else if (th && cfg_time_lim != 0 && nt >= int'(cfg_time_lim)) cs = 6;
            if (cs == 3) begin
                m_cv = 1; m_cause = 3; m_cb = m_bytes; m_cp = m_pkts;
                m_open = 1; m_bytes = int'(pkt_bytes); m_pkts = 1; m_ticks = 0;
            end else if (cs != 0) begin
                m_cv = 1; m_cause = cs; m_cb = nb; m_cp = np;
                m_open = 0; m_bytes = 0; m_pkts = 0; m_ticks = 0;
            end else begin
                if (pkt_valid) m_open = 1;
                m_bytes = nb; m_pkts = np; m_ticks = (nt > 31) ? 31 : nt;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (close_valid !== m_cv || win_open !== (m_open != 0) ||
                (m_cv && (int'(close_cause) != m_cause || int'(close_bytes) != m_cb ||
                          int'(close_pkts) != m_cp))) begin
                errors++;
                $display("FAIL R8 model compare t=%0t: act v=%0b c=%0d b=%0d p=%0d o=%0b exp v=%0b c=%0d b=%0d p=%0d o=%0d",
                         $time, close_valid, close_cause, close_bytes, close_pkts, win_open,
                         m_cv, m_cause, m_cb, m_cp, m_open);
            end
        end
    end

    task automatic cyc(input bit v, input int b, input bit e, input bit tf, input bit tc, input bit fc);
        pkt_valid = v; pkt_bytes = 16'(b); pkt_eof = e;
        tick_fine = tf; tick_coarse = tc; force_close = fc;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 0; pkt_eof = 0; tick_fine = 0; tick_coarse = 0; force_close = 0;
    endtask

    task automatic expect_close(input int cs, input int b, input int p, input string tag);
        checks++;
        if (close_valid !== 1'b1 || int'(close_cause) != cs || int'(close_bytes) != b || int'(close_pkts) != p) begin
            errors++;
            $display("FAIL %s: act v=%0b c=%0d b=%0d p=%0d exp v=1 c=%0d b=%0d p=%0d",
                     tag, close_valid, close_cause, close_bytes, close_pkts, cs, b, p);
        end
    endtask

    task automatic expect_none(input bit open_exp, input string tag);
        checks++;
        if (close_valid !== 1'b0 || win_open !== open_exp) begin
            errors++;
            $display("FAIL %s: act v=%0b o=%0b exp v=0 o=%0b", tag, close_valid, win_open, open_exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_none(0, "R1 reset state");

        // R2 soft byte limit, crossing packet included
        cyc(1, 1000, 0, 0, 0, 0); expect_none(1, "R2 first packet");
        cyc(1, 1000, 0, 0, 0, 0); expect_none(1, "R2 below limit");
        cyc(1, 100, 0, 0, 0, 0);  expect_close(4, 2100, 3, "R2 soft crossing");
        cyc(0, 0, 0, 0, 0, 0);    expect_none(0, "R8 pulse ends, window idle");

        // R3 hard byte limit
        cfg_hard_en = 1;
        cyc(1, 1500, 0, 0, 0, 0); expect_none(1, "R3 open");
        cyc(1, 1000, 0, 0, 0, 0); expect_close(3, 1500, 1, "R3 hard excludes packet");
        checks++;
        if (win_open !== 1'b1) begin errors++; $display("FAIL R3 reopen: act %0b exp 1", win_open); end
        cyc(1, 548, 0, 0, 0, 0);  expect_none(1, "R3 carried packet counted");
        cyc(1, 500, 0, 0, 0, 0);  expect_close(4, 2048, 3, "R3 exact limit closes soft");
        cyc(1, 3000, 0, 0, 0, 0); expect_close(4, 3000, 1, "R3 lone oversize packet kept");
        cfg_hard_en = 0;

        // R4 packet limit
        cfg_byte_kb = 6'd63; cfg_pkt_lim = 6'd3;
        cyc(1, 10, 0, 0, 0, 0); cyc(1, 10, 0, 0, 0, 0); expect_none(1, "R4 below count");
        cyc(1, 10, 0, 0, 0, 0); expect_close(5, 30, 3, "R4 packet limit");
        cfg_pkt_lim = 6'd0;
        for (int i = 0; i < 70; i++) begin
            cyc(1, 1, 0, 0, 0, 0);
            if (i == 69) expect_none(1, "R4 zero means unlimited");
        end
        cyc(0, 0, 0, 0, 0, 1); expect_close(1, 70, 70, "R7 force on open window");

        // R5 time limit
        cfg_time_lim = 5'd3; cfg_time_sel = 0;
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0);
        expect_none(0, "R5 ticks ignored while idle");
        cyc(1, 10, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0);
        expect_none(1, "R5 unselected base ignored");
        cyc(0, 0, 0, 1, 0, 0); cyc(0, 0, 0, 1, 0, 0); expect_none(1, "R5 two fine ticks");
        cyc(0, 0, 0, 1, 0, 0); expect_close(6, 10, 1, "R5 fine base timeout");
        cfg_time_sel = 1;
        cyc(1, 20, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 0); cyc(0, 0, 0, 1, 1, 0); expect_none(1, "R5 coarse two ticks");
        cyc(0, 0, 0, 0, 1, 0); expect_close(6, 20, 1, "R5 coarse base timeout");
        cfg_time_lim = 5'd0;
        cyc(1, 5, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 1, 0);
        expect_none(1, "R5 zero limit disables timer");
        cyc(0, 0, 0, 0, 0, 1); expect_close(1, 5, 1, "R7 force clears timer window");

        // R6 end-of-frame
        cyc(1, 10, 1, 0, 0, 0); expect_none(1, "R6 eof ignored when disabled");
        cfg_eof_en = 1;
        cyc(1, 5, 1, 0, 0, 0); expect_close(2, 15, 2, "R6 eof closes");

        // R7 force
        cyc(0, 0, 0, 0, 0, 1); expect_none(0, "R7 force on idle does nothing");
        cyc(1, 7, 0, 0, 0, 1); expect_close(1, 7, 1, "R7 force with packet");

        // R8 priority
        cfg_byte_kb = 6'd1; cfg_pkt_lim = 6'd1;
        cyc(1, 2000, 1, 0, 0, 1); expect_close(1, 2000, 1, "R8 force over eof");
        cyc(1, 2000, 1, 0, 0, 0); expect_close(2, 2000, 1, "R8 eof over byte");
        cyc(1, 2000, 0, 0, 0, 0); expect_close(4, 2000, 1, "R8 byte over packet");
        cyc(1, 10, 0, 0, 0, 0);   expect_close(5, 10, 1, "R8 packet limit of one");
        cfg_pkt_lim = 6'd0; cfg_eof_en = 0;

        // R9 disable drops window
        cyc(1, 10, 0, 0, 0, 0);
        cfg_enable = 0;
        cyc(1, 5000, 0, 0, 0, 0); expect_none(0, "R9 disabled ignores packet");
        cyc(0, 0, 0, 0, 0, 1);    expect_none(0, "R9 disabled ignores force");
        cfg_enable = 1;
        cyc(1, 1000, 0, 0, 0, 0);
        cyc(1, 100, 0, 0, 0, 0);  expect_close(4, 1100, 2, "R9 fresh window after disable");

        // Mixed random traffic checked against the model every clock (R10 totals)
        for (int i = 0; i < 4000; i++) begin
            if ((i % 300) == 0) begin
                cfg_byte_kb  = 6'($urandom_range(0, 8));
                cfg_time_lim = 5'($urandom_range(0, 6));
                cfg_pkt_lim  = 6'($urandom_range(0, 5));
                cfg_time_sel = 1'($urandom_range(0, 1));
                cfg_eof_en   = 1'($urandom_range(0, 1));
                cfg_hard_en  = 1'($urandom_range(0, 1));
                cfg_enable   = ($urandom_range(0, 9) != 0);
            end
            cyc($urandom_range(0, 2) == 0, $urandom_range(1, 3000), $urandom_range(0, 15) == 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 40) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule